// File: doc/BRIEF.md
# DRAM Early-Write Access Sequencer

This block sits between a host port and an array of dynamic RAM devices whose row and column addresses share one multiplexed address bus. Each host request names a single 36-bit word through a 22-bit word address. The sequencer splits that address into an 11-bit row half and an 11-bit column half. It pulls the row strobe of every bank it needs, moves the address bus to the column half, and lowers the column strobes of the selected byte lanes. It then either samples the returned word or leaves its write data on the shared data pins until the column strobes rise. It holds precharge until the random cycle time has elapsed and then accepts the next request.

The 36-bit word is four 9-bit lanes, and bit 8 of each lane carries parity. Every lane has its own column strobe, and strobe index equals lane index. Lanes 0 and 1 share row strobe 0, and lanes 2 and 3 share row strobe 1. Because the data pins are shared, every write is an early write: write enable is already low when the column strobe falls. A per-lane mask limits a write to chosen lanes. A separate refresh scheduler takes the bus through a request/grant pair. All timing windows are counted in clock cycles and set by parameters. The defaults assume a 5 ns clock.

Top module: `dram_seq`

## Requirements
- R1: During and after reset, both row strobes and all four column strobes are high, write enable is high, the data output enable is low, no response or grant is pending, and `req_ready` is high once reset is released.
- R2: The row strobe falls with the row half (`req_addr[21:11]`) on `dram_addr`. The address holds for `T_RAH` (2) cycles, then changes to the column half (`req_addr[10:0]`). The column strobes fall exactly `T_RCD` (4) cycles after the row strobe, and the column address stays stable while they are low.
- R3: A read lowers all four column strobes and both row strobes. A write lowers column strobe `i` only when `req_mask[i]` is 1. It lowers row strobe 0 only if mask bit 0 or 1 is set, and row strobe 1 only if mask bit 2 or 3 is set.
- R4: On a write, `we_n` is already low in the cycle before any column strobe falls. It never falls while a column strobe is low.
- R5: On a read, `we_n` stays high and `dq_oe` stays low for the whole access.
- R6: Column strobes stay low for at least max(`T_CAS`, `T_RAS`-`T_RCD`) = 8 cycles. The row strobe stays low at least `T_RAS` (12) cycles.
- R7: A read returns, through a one-cycle `rsp_valid` pulse, the value on `dq_in` at the clock edge where the column strobes rise. Every accepted read produces exactly one response.
- R8: Successive row-strobe falls are at least `T_RC` (22) cycles apart. Each row strobe is high for at least `T_RP` (8) cycles before it falls again.
- R9: On a write, `dq_oe` is high from the accepting edge, through the column-strobe low period, and drops exactly one cycle after the column strobes rise.
- R10: `ref_gnt` rises only from idle. When `ref_req` and `req_valid` arrive in the same idle cycle, refresh wins. While granted, all strobes stay high and `req_ready` is low. The grant falls one cycle after `ref_req` drops.
- R11: `req_ready` is low while any access or refresh is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both high.
- R12: A write whose mask is all zero is accepted and completes, but it lowers no row or column strobe and leaves stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper half |
| req_wdata | input | 36 | Write word, four 9-bit lanes |
| req_mask | input | 4 | Per-lane write mask |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 36 | Read word |
| ref_req | input | 1 | Refresh scheduler asks for the bus |
| ref_gnt | output | 1 | Bus granted to refresh |
| dram_addr | output | 11 | Multiplexed row/column address |
| ras_n | output | 2 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per lane, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 36 | Data driven to the shared pins |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 36 | Data read from the shared pins |

## Verification
A refresh request and a host request can reach the idle sequencer in the same cycle. The bench raises `ref_req` and `req_valid` on the same falling edge. It expects the grant on the next edge with no strobe activity, and it expects the held request to start only after the grant is released. The other overlap is a refresh request that arrives while an access is in flight. In that case the grant must wait until the access has finished and its read response has been delivered.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int ADDR_W = 22,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int BANKS  = 2,
  parameter int T_RAH  = 2,
  parameter int T_RCD  = 4,
  parameter int T_CAS  = 3,
  parameter int T_RAS  = 12,
  parameter int T_RP   = 8,
  parameter int T_RC   = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  input  logic [LANES-1:0]          req_mask,
  output logic                      rsp_valid,
  output logic [LANES*LANE_W-1:0]   rsp_rdata,
  input  logic                      ref_req,
  output logic                      ref_gnt,
  output logic [ADDR_W/2-1:0]       dram_addr,
  output logic [BANKS-1:0]          ras_n,
  output logic [LANES-1:0]          cas_n,
  output logic                      we_n,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe,
  input  logic [LANES*LANE_W-1:0]   dq_in
);
  localparam int RA_W   = ADDR_W / 2;
  localparam int LPB    = LANES / BANKS;
  localparam int CAS_LO = (T_CAS > T_RAS - T_RCD) ? T_CAS : (T_RAS - T_RCD);
  localparam int PRE_N  = (T_RP > T_RC - T_RCD - CAS_LO) ? T_RP : (T_RC - T_RCD - CAS_LO);
  localparam int CNT_W  = $clog2(T_RCD + CAS_LO + PRE_N + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             is_wr;
  logic [LANES-1:0] lanes;
  logic [RA_W-1:0]  col_q;
  logic [LANES-1:0] lane_sel;
  logic [BANKS-1:0] bank_sel;

  assign req_ready = (st == S_IDLE) && !ref_req;
  assign lane_sel  = req_write ? req_mask : {LANES{1'b1}};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_sel[b] = |lane_sel[b*LPB +: LPB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      lanes     <= '0;
      col_q     <= '0;
      dram_addr <= '0;
      ras_n     <= '1;
      cas_n     <= '1;
      we_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ref_gnt   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            st      <= S_REF;
          end else if (req_valid) begin
            st        <= S_ROW;
            cnt       <= '0;
            is_wr     <= req_write;
            lanes     <= lane_sel;
            col_q     <= req_addr[RA_W-1:0];
            dram_addr <= req_addr[ADDR_W-1 -: RA_W];
            ras_n     <= ~bank_sel;
            we_n      <= ~req_write;
            dq_oe     <= req_write;
            dq_out    <= req_wdata;
          end
        end
        S_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            st      <= S_IDLE;
          end
        end
        S_ROW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(T_RAH - 1)) dram_addr <= col_q;
          if (cnt == CNT_W'(T_RCD - 1)) begin
            st    <= S_COL;
            cnt   <= '0;
            cas_n <= ~lanes;
          end
        end
        S_COL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(CAS_LO - 1)) begin
            st    <= S_PRE;
            cnt   <= '0;
            cas_n <= '1;
            ras_n <= '1;
            we_n  <= 1'b1;
            if (!is_wr) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dq_in;
            end
          end
        end
        S_PRE: begin
          cnt   <= cnt + 1'b1;
          dq_oe <= 1'b0;
          if (cnt == CNT_W'(PRE_N - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int LANES = 4,
  parameter int BANKS = 2,
  parameter int RA_W  = 11,
  parameter int T_RCD = 4,
  parameter int T_CAS = 3,
  parameter int T_RAS = 12,
  parameter int T_RC  = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BANKS-1:0] ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic [RA_W-1:0]  dram_addr,
  input logic             rsp_valid,
  input logic             ref_gnt,
  input logic             req_ready
);
  localparam int LPB    = LANES / BANKS;
  localparam int CAS_LO = (T_CAS > T_RAS - T_RCD) ? T_CAS : (T_RAS - T_RCD);
  localparam int SAT    = T_RC + T_RAS + T_CAS;
  localparam int CW     = $clog2(SAT + 1) + 1;

  logic ras_lo, cas_hi, ras_lo_q, cas_hi_q, ras_fell, ras_rose, cas_fell, cas_rose;
  logic [CW-1:0] ras_t, cas_t, gap;

  assign ras_lo   = ~&ras_n;
  assign cas_hi   = &cas_n;
  assign ras_fell = ras_lo && !ras_lo_q;
  assign ras_rose = !ras_lo && ras_lo_q;
  assign cas_fell = !cas_hi && cas_hi_q;
  assign cas_rose = cas_hi && !cas_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_q <= 1'b0;
      cas_hi_q <= 1'b1;
      ras_t    <= '0;
      cas_t    <= '0;
      gap      <= CW'(SAT);
    end else begin
      ras_lo_q <= ras_lo;
      cas_hi_q <= cas_hi;
      if (ras_fell) begin
        ras_t <= CW'(1);
        gap   <= CW'(1);
      end else begin
        if (ras_t != CW'(SAT)) ras_t <= ras_t + 1'b1;
        if (gap != CW'(SAT)) gap <= gap + 1'b1;
      end
      if (cas_fell) cas_t <= CW'(1);
      else if (cas_t != CW'(SAT)) cas_t <= cas_t + 1'b1;
    end
  end

  p_ras_to_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fell |-> ras_t >= CW'(T_RCD));
  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fell |=> $stable(dram_addr));
  p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_hi && !cas_hi_q) |-> $stable(dram_addr));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_lane_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n[l] |-> !ras_n[l/LPB]);
  end

  p_we_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> cas_hi);
  p_we_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_hi && !we_n) |-> !$past(we_n));
  p_read_no_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_hi && we_n) |-> !dq_oe);
  p_cas_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rose |-> cas_t >= CW'(CAS_LO));
  p_ras_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rose |-> ras_t >= CW'(T_RAS));
  p_rsp_at_cas_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cas_rose);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_cycle_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fell |-> gap >= CW'(T_RC));
  p_write_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_hi && !we_n) |-> dq_oe);
  p_ref_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (!ras_lo && cas_hi && !req_ready));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ras_lo |-> !req_ready);
endmodule

bind dram_seq dram_seq_chk #(
  .LANES(LANES), .BANKS(BANKS), .RA_W(ADDR_W/2), .T_RCD(T_RCD),
  .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_oe(dq_oe), .dram_addr(dram_addr), .rsp_valid(rsp_valid),
  .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [21:0] req_addr;
  logic [35:0] req_wdata;
  logic [3:0]  req_mask;
  logic        rsp_valid;
  logic [35:0] rsp_rdata;
  logic        ref_req, ref_gnt;
  logic [10:0] dram_addr;
  logic [1:0]  ras_n;
  logic [3:0]  cas_n;
  logic        we_n;
  logic [35:0] dq_out;
  logic        dq_oe;
  logic [35:0] dq_in;

  always #2.5 clk = ~clk;

  dram_seq u0 (.*);

  int checks = 0, fails = 0, nras = 0;
  bit done = 0;
  logic [35:0] rq[$];
  logic [35:0] shadow[logic [21:0]];
  logic [35:0] mem[logic [21:0]];
  logic [10:0] row_l[2];
  logic [10:0] col_l[4];
  bit          cur_wr;
  logic [21:0] cur_addr;
  logic [3:0]  cur_mask;
  int t_ras = 0, t_cas = 0, t_gap = 1000, t_rh = 1000;
  logic [1:0] p_ras = 2'b11;
  logic [3:0] p_cas = 4'hF;
  logic p_we = 1'b1, p_rsp = 1'b0;
  bit oe_pend = 0;
  logic [21:0] key;
  logic [35:0] tmp, exp_v;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 2'b11; p_cas = 4'hF; p_we = 1'b1; p_rsp = 1'b0; dq_in = '0;
    end else begin
      t_ras++; t_cas++; t_gap++; t_rh++;
      if (oe_pend) begin
        chk(!dq_oe, "R9 oe drops one cycle after CAS rise", dq_oe, 0);
        oe_pend = 0;
      end
      if (~&ras_n && &p_ras) begin
        nras++;
        chk(dram_addr == cur_addr[21:11], "R2 row address", dram_addr, cur_addr[21:11]);
        chk(ras_n == ~{|cur_mask[3:2], |cur_mask[1:0]}, "R3 bank strobes", ras_n,
            ~{|cur_mask[3:2], |cur_mask[1:0]});
        chk(!req_ready, "R11 busy during access", req_ready, 0);
        chk(t_gap >= 22, "R8 cycle time", t_gap, 22);
        chk(t_rh >= 8, "R8 precharge", t_rh, 8);
        t_ras = 0; t_gap = 0;
      end
      if (&ras_n && ~&p_ras) t_rh = 0;
      if (~&cas_n && &p_cas) begin
        chk(t_ras == 4, "R2 RAS-to-CAS delay", t_ras, 4);
        chk(dram_addr == cur_addr[10:0], "R2 column address", dram_addr, cur_addr[10:0]);
        chk(cas_n == ~cur_mask, "R3 lane strobes", cas_n, ~cur_mask);
        if (cur_wr) begin
          chk(!p_we && !we_n, "R4 early write", {p_we, we_n}, 0);
          chk(dq_oe, "R9 oe during write", dq_oe, 1);
        end else begin
          chk(we_n && !dq_oe, "R5 read keeps W high, oe low", {we_n, dq_oe}, 2'b10);
        end
        t_cas = 0;
      end
      if (&cas_n && ~&p_cas) begin
        chk(t_cas >= 8 && t_ras >= 12, "R6 strobe widths", {t_cas[15:0], t_ras[15:0]}, {16'd8, 16'd12});
        if (cur_wr) begin
          chk(dq_oe, "R9 oe held at CAS rise", dq_oe, 1);
          oe_pend = 1;
        end
      end
      if (rsp_valid) begin
        chk(!p_rsp, "R7 single-cycle response", p_rsp, 0);
        if (rq.size() == 0) chk(0, "R7 unexpected response", rsp_rdata, 0);
        else begin
          exp_v = rq.pop_front();
          chk(rsp_rdata == exp_v, "R7 read data", rsp_rdata, exp_v);
        end
      end
      for (int b = 0; b < 2; b++)
        if (!ras_n[b] && p_ras[b]) row_l[b] = dram_addr;
      for (int l = 0; l < 4; l++)
        if (!cas_n[l] && p_cas[l]) begin
          col_l[l] = dram_addr;
          if (!we_n) begin
            key = {row_l[l/2], dram_addr};
            if (!mem.exists(key)) mem[key] = '0;
            tmp = mem[key];
            tmp[l*9 +: 9] = dq_out[l*9 +: 9];
            mem[key] = tmp;
          end
        end
      tmp = '0;
      for (int l = 0; l < 4; l++)
        if (!cas_n[l] && we_n) begin
          key = {row_l[l/2], col_l[l]};
          if (mem.exists(key)) tmp[l*9 +: 9] = mem[key][l*9 +: 9];
        end
      dq_in = tmp;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_rsp = rsp_valid;
    end
  end

  task automatic issue(input bit wr, input logic [21:0] a, input logic [35:0] d, input logic [3:0] m);
    logic [35:0] old;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_mask = wr ? m : 4'hF;
    old = shadow.exists(a) ? shadow[a] : '0;
    if (wr) begin
      for (int l = 0; l < 4; l++) if (m[l]) old[l*9 +: 9] = d[l*9 +: 9];
      shadow[a] = old;
    end else rq.push_back(old);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int n0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    req_mask = '0; ref_req = 0; dq_in = '0; cur_wr = 0; cur_addr = '0; cur_mask = 4'hF;
    repeat (5) @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 4'hF, "R1 strobes idle in reset", {ras_n, cas_n}, 6'h3F);
    chk(we_n && !dq_oe && !rsp_valid && !ref_gnt, "R1 controls idle in reset",
        {we_n, dq_oe, rsp_valid, ref_gnt}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    issue(0, 22'h012345, '0, 4'h0);
    issue(1, 22'h012345, 36'h9_8765_4321, 4'hF);
    issue(0, 22'h012345, '0, 4'h0);
    issue(1, 22'h3FFFFF, 36'hF_FFFF_FFFF, 4'hF);
    issue(1, 22'h000000, 36'h1_0080_4020, 4'hF);
    issue(0, 22'h3FFFFF, '0, 4'h0);
    issue(0, 22'h000000, '0, 4'h0);
    issue(1, 22'h012345, 36'hA_AAAA_AAAA, 4'b0101);
    issue(0, 22'h012345, '0, 4'h0);
    issue(1, 22'h012345, 36'h5_5555_5555, 4'b0011);
    issue(1, 22'h012345, 36'hC_3C3C_3C3C, 4'b1000);
    issue(0, 22'h012345, '0, 4'h0);

    wait_idle();
    n0 = nras;
    issue(1, 22'h000000, 36'h7_7777_7777, 4'b0000);
    wait_idle();
    chk(nras == n0, "R12 zero-mask write drives no strobes", nras, n0);
    issue(0, 22'h000000, '0, 4'h0);

    wait_idle();
    @(negedge clk);
    cur_wr = 0; cur_addr = 22'h200400; cur_mask = 4'hF;
    rq.push_back(shadow.exists(22'h200400) ? shadow[22'h200400] : '0);
    ref_req = 1; req_valid = 1; req_write = 0; req_addr = 22'h200400; req_mask = '0;
    @(negedge clk);
    chk(ref_gnt && !req_ready && ras_n == 2'b11, "R10 refresh wins tie",
        {ref_gnt, req_ready, ras_n}, 4'b1011);
    repeat (5) @(negedge clk);
    chk(ref_gnt && ras_n == 2'b11 && cas_n == 4'hF, "R10 strobes quiet while granted",
        {ref_gnt, ras_n, cas_n}, 7'h7F);
    ref_req = 0;
    @(negedge clk);
    chk(!ref_gnt && req_ready, "R10 grant released", {ref_gnt, req_ready}, 2'b01);
    @(negedge clk);
    req_valid = 0;

    issue(1, 22'h155AAA, 36'h1_2345_6789, 4'hF);
    issue(0, 22'h155AAA, '0, 4'h0);
    ref_req = 1;
    @(negedge clk);
    chk(!ref_gnt, "R10 no grant during access", ref_gnt, 0);
    while (!ref_gnt) @(negedge clk);
    chk(rq.size() == 0 && ras_n == 2'b11, "R10 grant after read completes",
        {rq.size() == 0, ras_n}, 3'b111);
    ref_req = 0;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      issue(1, 22'(i * 22'h0C0301), {4{9'(9'h101 << i)}}, 4'hF);
      issue(0, 22'(i * 22'h0C0301), '0, 4'h0);
    end

    wait_idle();
    repeat (30) @(negedge clk);
    chk(rq.size() == 0, "R7 every read answered", rq.size(), 0);
    summary();
  end
endmodule